// File: doc/BRIEF.md
# Coalesced Translation Response Distributor

This block sits below a request coalescer in an address translation path. Several requests that hit the same virtual page were merged into one group, and only the group's leader was sent down for translation. When the translated entry comes back, this block finds the outstanding group for that page in an external outstanding table. It then hands a complete response to every member of the group, each on the upstream port the member came in on.

The returned entry carries a physical address, a page-size select, an uncacheable flag, an entry-valid bit and the hit level. The leader gets the physical address exactly as it was returned. Every other member gets a physical address rebuilt from the shared physical page base and its own page offset. Members leave one per cycle, in table order. The response input is held not-ready until the whole group has left.

In the cycle the last member is presented, the block pulses a free strobe with the group's page key, so that the outstanding entry can be reused at once. A response whose page has no usable outstanding entry is dropped, and a sticky error flag is raised.

Top module: `xlat_rsp_fanout`

## Requirements
- R1: `rsp_ready` is high whenever no group is being dispatched. It goes low in the cycle after a response is accepted and found, and stays low until the cycle in which the group's last member is presented, where it is high again.
- R2: The page key sent to the table is the response virtual address with its low 12 bits cleared when `rsp_huge` is 0 (4 KiB page), or its low 21 bits cleared when `rsp_huge` is 1 (2 MiB page).
- R3: Member 0 of a group receives `rsp_paddr` unchanged, two cycles after the response is accepted.
- R4: Each member k > 0 receives `rsp_paddr` with its page-offset bits cleared, OR'd with that member's own virtual-address bits below the page size. The page size is the one selected by `rsp_huge` (12 or 21 offset bits).
- R5: Every member's response carries the returned uncacheable flag, entry-valid bit and hit level.
- R6: Members are presented one per cycle in table order (index 0 upward), starting two cycles after acceptance. For each member, exactly one bit of `up_valid` is high, bit p, where p is the member's recorded port. The member's own virtual address appears on `up_vaddr`.
- R7: `up_pop` is high for a member whose prefetch flag is 0 and low for a prefetch member.
- R8: `tbl_free` pulses for exactly one cycle, in the same cycle as the last member's response, with `tbl_free_key` equal to the group's page key. It is low at every other time.
- R9: An accepted response for which the table reports no hit, or a member count of zero, is dropped. It produces no `up_valid`, no `tbl_free`, and no drop in `rsp_ready`, and it sets `err_flag`, which stays set until reset.
- R10: After reset `rsp_ready` is 1, while `up_valid`, `tbl_free` and `err_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_valid | input | 1 | Translated entry present |
| rsp_ready | output | 1 | Block can accept an entry |
| rsp_vaddr | input | VA_W | Virtual address of the group leader |
| rsp_paddr | input | PA_W | Translated physical address of the leader |
| rsp_huge | input | 1 | Page size: 0 = 4 KiB, 1 = 2 MiB |
| rsp_uncache | input | 1 | Uncacheable flag of the entry |
| rsp_ok | input | 1 | Entry-valid bit |
| rsp_level | input | LVL_W | Level at which the translation hit |
| tbl_key | output | VA_W | Page key for the table read |
| tbl_idx | output | CNT_W | Member index for the table read |
| tbl_hit | input | 1 | Table holds an entry for `tbl_key` |
| tbl_cnt | input | CNT_W | Member count of that entry |
| tbl_va | input | VA_W | Virtual address of member `tbl_idx` |
| tbl_port | input | PORT_W | Upstream port of member `tbl_idx` |
| tbl_pf | input | 1 | Prefetch flag of member `tbl_idx` |
| tbl_free | output | 1 | Release the entry at `tbl_free_key` |
| tbl_free_key | output | VA_W | Page key to release |
| up_valid | output | NPORT | One-hot per-port response strobe |
| up_paddr | output | PA_W | Member physical address |
| up_vaddr | output | VA_W | Member virtual address |
| up_uncache | output | 1 | Copied uncacheable flag |
| up_ok | output | 1 | Copied entry-valid bit |
| up_level | output | LVL_W | Copied hit level |
| up_pop | output | 1 | Pop the member's request-count record |
| err_flag | output | 1 | Sticky no-entry error |

## Verification
The hardest case to reach is a 2 MiB response whose virtual address has nonzero bits between bit 12 and bit 20. It finds its group only if the key is masked at the large size, and it drives offsets that differ from the 4 KiB rebuild. The bench builds a group whose members' offsets spread across that whole range. It then sends the same address marked as 4 KiB, which must miss, leave the table entry untouched and raise the error. A 15-member group exercises the member counter at its largest value and routes to every port.

// File: rtl/xlat_rsp_fanout.sv
module xlat_rsp_fanout #(
  parameter int VA_W     = 32,
  parameter int PA_W     = 36,
  parameter int NPORT    = 4,
  parameter int CNT_W    = 4,
  parameter int LVL_W    = 2,
  parameter int SMALL_SH = 12,
  parameter int LARGE_SH = 21
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rsp_valid,
  output logic                     rsp_ready,
  input  logic [VA_W-1:0]          rsp_vaddr,
  input  logic [PA_W-1:0]          rsp_paddr,
  input  logic                     rsp_huge,
  input  logic                     rsp_uncache,
  input  logic                     rsp_ok,
  input  logic [LVL_W-1:0]         rsp_level,
  output logic [VA_W-1:0]          tbl_key,
  output logic [CNT_W-1:0]         tbl_idx,
  input  logic                     tbl_hit,
  input  logic [CNT_W-1:0]         tbl_cnt,
  input  logic [VA_W-1:0]          tbl_va,
  input  logic [$clog2(NPORT)-1:0] tbl_port,
  input  logic                     tbl_pf,
  output logic                     tbl_free,
  output logic [VA_W-1:0]          tbl_free_key,
  output logic [NPORT-1:0]         up_valid,
  output logic [PA_W-1:0]          up_paddr,
  output logic [VA_W-1:0]          up_vaddr,
  output logic                     up_uncache,
  output logic                     up_ok,
  output logic [LVL_W-1:0]         up_level,
  output logic                     up_pop,
  output logic                     err_flag
);

  localparam logic [VA_W-1:0] VM_S = VA_W'((64'd1 << SMALL_SH) - 64'd1);
  localparam logic [VA_W-1:0] VM_L = VA_W'((64'd1 << LARGE_SH) - 64'd1);
  localparam logic [PA_W-1:0] PM_S = PA_W'((64'd1 << SMALL_SH) - 64'd1);
  localparam logic [PA_W-1:0] PM_L = PA_W'((64'd1 << LARGE_SH) - 64'd1);

  logic             busy_q;
  logic [VA_W-1:0]  key_q;
  logic [PA_W-1:0]  paddr_q;
  logic             huge_q, unc_q, ok_q;
  logic [LVL_W-1:0] lvl_q;
  logic [CNT_W-1:0] idx_q, last_q;

  logic [NPORT-1:0] upv_q;
  logic [PA_W-1:0]  upa_q;
  logic [VA_W-1:0]  uva_q, fkey_q;
  logic             uunc_q, uok_q, upop_q, free_q, err_q;
  logic [LVL_W-1:0] ulvl_q;

  logic [VA_W-1:0] rsp_key;
  logic            accept, found, at_last;
  logic [VA_W-1:0] vmask;
  logic [PA_W-1:0] pmask, rebuilt;

  assign rsp_key  = rsp_vaddr & ~(rsp_huge ? VM_L : VM_S);
  assign rsp_ready = ~busy_q;
  assign accept   = rsp_valid & ~busy_q;
  assign tbl_key  = busy_q ? key_q : rsp_key;
  assign tbl_idx  = busy_q ? idx_q : '0;
  assign found    = tbl_hit && (tbl_cnt != '0);
  assign at_last  = busy_q && (idx_q == last_q);
  assign vmask    = huge_q ? VM_L : VM_S;
  assign pmask    = huge_q ? PM_L : PM_S;
  assign rebuilt  = (paddr_q & ~pmask) | PA_W'(tbl_va & vmask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      key_q   <= '0;
      paddr_q <= '0;
      huge_q  <= 1'b0;
      unc_q   <= 1'b0;
      ok_q    <= 1'b0;
      lvl_q   <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      err_q   <= 1'b0;
    end else if (accept) begin
      if (found) begin
        busy_q  <= 1'b1;
        key_q   <= rsp_key;
        paddr_q <= rsp_paddr;
        huge_q  <= rsp_huge;
        unc_q   <= rsp_uncache;
        ok_q    <= rsp_ok;
        lvl_q   <= rsp_level;
        idx_q   <= '0;
        last_q  <= tbl_cnt - 1'b1;
      end else begin
        err_q <= 1'b1;
      end
    end else if (busy_q) begin
      idx_q <= idx_q + 1'b1;
      if (at_last) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upv_q  <= '0;
      upa_q  <= '0;
      uva_q  <= '0;
      uunc_q <= 1'b0;
      uok_q  <= 1'b0;
      ulvl_q <= '0;
      upop_q <= 1'b0;
      free_q <= 1'b0;
      fkey_q <= '0;
    end else begin
      upv_q  <= busy_q ? (NPORT'(1) << tbl_port) : '0;
      upa_q  <= (idx_q == '0) ? paddr_q : rebuilt;
      uva_q  <= tbl_va;
      uunc_q <= unc_q;
      uok_q  <= ok_q;
      ulvl_q <= lvl_q;
      upop_q <= busy_q && !tbl_pf;
      free_q <= at_last;
      fkey_q <= key_q;
    end
  end

  assign up_valid     = upv_q;
  assign up_paddr     = upa_q;
  assign up_vaddr     = uva_q;
  assign up_uncache   = uunc_q;
  assign up_ok        = uok_q;
  assign up_level     = ulvl_q;
  assign up_pop       = upop_q;
  assign tbl_free     = free_q;
  assign tbl_free_key = fkey_q;
  assign err_flag     = err_q;

  p_onehot_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(up_valid));

  p_ready_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && tbl_hit && tbl_cnt != '0) |=> !rsp_ready);

  p_leader_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && tbl_hit && tbl_cnt != '0) |=> ##1 (up_paddr == $past(rsp_paddr, 2)));

  p_free_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_free |-> rsp_ready);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  p_miss_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && !(tbl_hit && tbl_cnt != '0)) |=> (rsp_ready && !tbl_free && err_flag));

endmodule

// File: tb/xlat_rsp_fanout_tb_top.sv
`timescale 1ns/1ps
module xlat_rsp_fanout_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  always #2 clk = ~clk;

  logic        rsp_valid = 0, rsp_ready;
  logic [31:0] rsp_vaddr = 0;
  logic [35:0] rsp_paddr = 0;
  logic        rsp_huge = 0, rsp_uncache = 0, rsp_ok = 0;
  logic [1:0]  rsp_level = 0;
  logic [31:0] tbl_key;
  logic [3:0]  tbl_idx;
  logic        tbl_hit;
  logic [3:0]  tbl_cnt;
  logic [31:0] tbl_va;
  logic [1:0]  tbl_port;
  logic        tbl_pf;
  logic        tbl_free;
  logic [31:0] tbl_free_key;
  logic [3:0]  up_valid;
  logic [35:0] up_paddr;
  logic [31:0] up_vaddr;
  logic        up_uncache, up_ok, up_pop, err_flag;
  logic [1:0]  up_level;

  xlat_rsp_fanout dut_i (
    .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_vaddr(rsp_vaddr), .rsp_paddr(rsp_paddr), .rsp_huge(rsp_huge),
    .rsp_uncache(rsp_uncache), .rsp_ok(rsp_ok), .rsp_level(rsp_level),
    .tbl_key(tbl_key), .tbl_idx(tbl_idx), .tbl_hit(tbl_hit), .tbl_cnt(tbl_cnt),
    .tbl_va(tbl_va), .tbl_port(tbl_port), .tbl_pf(tbl_pf), .tbl_free(tbl_free),
    .tbl_free_key(tbl_free_key), .up_valid(up_valid), .up_paddr(up_paddr),
    .up_vaddr(up_vaddr), .up_uncache(up_uncache), .up_ok(up_ok),
    .up_level(up_level), .up_pop(up_pop), .err_flag(err_flag));

  logic        t_v   [4];
  logic [31:0] t_key [4];
  logic [3:0]  t_cnt [4];
  logic [31:0] m_va  [4][16];
  logic [1:0]  m_port[4][16];
  logic        m_pf  [4][16];

  always_comb begin
    tbl_hit = 0; tbl_cnt = 0; tbl_va = 0; tbl_port = 0; tbl_pf = 0;
    for (int g = 0; g < 4; g++)
      if (t_v[g] && t_key[g] == tbl_key) begin
        tbl_hit  = 1;
        tbl_cnt  = t_cnt[g];
        tbl_va   = m_va[g][tbl_idx];
        tbl_port = m_port[g][tbl_idx];
        tbl_pf   = m_pf[g][tbl_idx];
      end
  end

  int checks = 0, errors = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] exp_pa(int k, logic [35:0] pa, logic [31:0] va, logic huge);
    logic [35:0] m;
    m = huge ? 36'h1FFFFF : 36'hFFF;
    return (k == 0) ? pa : ((pa & ~m) | ({4'h0, va} & m));
  endfunction

  task automatic drive_rsp(logic [31:0] va, logic [35:0] pa, logic huge, logic unc, logic ok, logic [1:0] lvl);
    rsp_valid = 1; rsp_vaddr = va; rsp_paddr = pa; rsp_huge = huge;
    rsp_uncache = unc; rsp_ok = ok; rsp_level = lvl;
    @(negedge clk);
    rsp_valid = 0;
  endtask

  task automatic run_group(int g, logic [35:0] pa, logic huge, logic unc, logic ok, logic [1:0] lvl);
    int n;
    n = int'(t_cnt[g]);
    @(negedge clk);
    drive_rsp(m_va[g][0], pa, huge, unc, ok, lvl);
    chk("R1 ready low after accept", rsp_ready, 0);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk("R6 port strobe", up_valid, 4'b1 << m_port[g][k]);
      chk("R6 member vaddr", up_vaddr, m_va[g][k]);
      if (k == 0) chk("R3 leader paddr", up_paddr, pa);
      else        chk("R4 member paddr", up_paddr, exp_pa(k, pa, m_va[g][k], huge));
      chk("R5 uncacheable", up_uncache, unc);
      chk("R5 entry valid", up_ok, ok);
      chk("R5 hit level", up_level, lvl);
      chk("R7 pop flag", up_pop, !m_pf[g][k]);
      chk("R8 free strobe", tbl_free, k == n - 1);
      chk("R1 ready during drain", rsp_ready, k == n - 1);
      if (k == n - 1) chk("R8 free key", tbl_free_key, t_key[g]);
    end
    @(negedge clk);
    chk("R6 quiet after group", up_valid, 0);
    chk("R8 free single pulse", tbl_free, 0);
    t_v[g] = 0;
  endtask

  task automatic test_reset();
    chk("R10 ready", rsp_ready, 1);
    chk("R10 up_valid", up_valid, 0);
    chk("R10 free", tbl_free, 0);
    chk("R10 err", err_flag, 0);
  endtask

  task automatic test_small_page();
    t_v[0] = 1; t_key[0] = 32'h12345000; t_cnt[0] = 3;
    m_va[0][0] = 32'h12345010; m_port[0][0] = 2'd0; m_pf[0][0] = 0;
    m_va[0][1] = 32'h12345ABC; m_port[0][1] = 2'd2; m_pf[0][1] = 1;
    m_va[0][2] = 32'h12345FF8; m_port[0][2] = 2'd1; m_pf[0][2] = 0;
    run_group(0, 36'h987654010, 0, 0, 1, 2'd1);
  endtask

  task automatic load_huge();
    t_v[1] = 1; t_key[1] = 32'h40000000; t_cnt[1] = 4;
    m_va[1][0] = 32'h40012344; m_port[1][0] = 2'd3; m_pf[1][0] = 0;
    m_va[1][1] = 32'h401FFFFF; m_port[1][1] = 2'd0; m_pf[1][1] = 0;
    m_va[1][2] = 32'h40000000; m_port[1][2] = 2'd1; m_pf[1][2] = 1;
    m_va[1][3] = 32'h40100008; m_port[1][3] = 2'd3; m_pf[1][3] = 0;
  endtask

  task automatic test_huge_page();
    load_huge();
    run_group(1, 36'h3A0012344, 1, 1, 0, 2'd3);
  endtask

  task automatic test_single();
    t_v[2] = 1; t_key[2] = 32'h00007000; t_cnt[2] = 1;
    m_va[2][0] = 32'h00007123; m_port[2][0] = 2'd2; m_pf[2][0] = 1;
    run_group(2, 36'hFFFFFF123, 0, 1, 1, 2'd2);
  endtask

  task automatic test_long_group();
    t_v[3] = 1; t_key[3] = 32'hABCDE000; t_cnt[3] = 15;
    for (int k = 0; k < 15; k++) begin
      m_va[3][k]   = 32'hABCDE000 | (k * 32'h111);
      m_port[3][k] = 2'(k);
      m_pf[3][k]   = k[0];
    end
    run_group(3, 36'h0000C3456, 0, 0, 1, 2'd0);
  endtask

  task automatic test_zero_count();
    t_v[2] = 1; t_key[2] = 32'h55555000; t_cnt[2] = 0;
    @(negedge clk);
    drive_rsp(32'h55555040, 36'h1, 0, 0, 1, 2'd0);
    chk("R9 zero count sets err", err_flag, 1);
    chk("R9 zero count ready stays", rsp_ready, 1);
    @(negedge clk);
    chk("R9 zero count no output", up_valid, 0);
    chk("R9 zero count no free", tbl_free, 0);
    t_v[2] = 0;
  endtask

  task automatic test_size_miss();
    load_huge();
    @(negedge clk);
    drive_rsp(32'h40012344, 36'h3A0012344, 0, 0, 1, 2'd0);
    chk("R2 small mask misses large key", err_flag, 1);
    chk("R9 miss ready stays", rsp_ready, 1);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R9 miss no output", up_valid, 0);
      chk("R9 miss no free", tbl_free, 0);
    end
    run_group(1, 36'h7E0000000, 1, 0, 1, 2'd1);
    chk("R9 err stays set", err_flag, 1);
  endtask

  initial begin
    for (int g = 0; g < 4; g++) t_v[g] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_small_page();
    test_huge_page();
    test_single();
    test_long_group();
    chk("R9 err clear before miss", err_flag, 0);
    test_zero_count();
    test_size_miss();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule